// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects interrupt requests from eight sources and presents one interrupt line to a small CPU. A request is latched on the rising edge of its input. Line 0 has the highest priority and line 7 the lowest. When the CPU acknowledges, the block moves the winning request into an in-service set and returns a vector equal to a programmable base plus the line number. A line stays in service until the CPU writes an end-of-interrupt command. While it is in service, that line and every lower-priority line are held off, even if new edges arrive on them. A higher-priority line can still interrupt.

Two copies can be chained to serve more sources. The secondary's interrupt output feeds line 2 of the primary, and the primary's cascade-enable input is tied high. When the primary grants line 2, it returns no vector. Instead it pulses a cascade-acknowledge output, and that pulse serves as the secondary's acknowledge. The secondary then supplies its own vector. Each controller keeps its own in-service set, so the CPU ends a cascaded interrupt by writing end-of-interrupt to both controllers.

The bus has two ports. Offset 0 is the command port and offset 1 is the data port. Writing 20h to the command port is a non-specific end-of-interrupt. Any command byte with bit 7 set arms a base load. Ordinary data writes set the mask.

The command decoder is a two-state machine:
- RUN is the normal state.
- A command write with bit 7 set moves RUN to BASE_ARMED (transition "arm").
- In BASE_ARMED, a data write loads the base and returns the machine to RUN (transition "load").
- In BASE_ARMED, a command write with bit 7 clear is executed and returns the machine to RUN (transition "cancel").

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, no request is pending and no line is in service. `int_out`, `vec_valid` and `casc_ack` are low, the mask is 00h (all lines enabled), and the vector base equals the `RESET_BASE` parameter.
- R2: A rising edge on `irq_in[n]` sets a pending request for line n. With line n unmasked and not blocked, `int_out` is high in the cycle after the edge is sampled.
- R3: A write to offset 1 in state RUN loads the mask, where bit n = 1 masks line n. A masked pending request keeps `int_out` low but stays latched. Clearing the mask bit later raises `int_out`.
- R4: When several unmasked requests are pending, an acknowledge grants the lowest-numbered line.
- R5: `inta` sampled high while `int_out` is high moves the granted line from pending to in-service. In the next cycle `vec_valid` pulses for one cycle with `vec_out` = base + line.
- R6: A pending line is forwarded only when it is strictly higher in priority (lower numbered) than every in-service line. A higher-priority request therefore raises `int_out` while a lower one is in service.
- R7: A new edge on a line that is already in service is latched, but `int_out` stays low for it until an end-of-interrupt removes that line from service.
- R8: Writing 20h to offset 0 clears only the highest-priority (lowest-numbered) in-service line.
- R9: A command write with bit 7 set, followed by a write to offset 1, loads the vector base. That data write leaves the mask unchanged.
- R10: With `casc_en` high, a grant of line 2 pulses `casc_ack` instead of `vec_valid`, and line 2 becomes in service.
- R11: In a two-controller chain, the secondary returns its own base + line. After an end-of-interrupt to the secondary only, the primary's line 2 stays in service and keeps lines 2 to 7 of the primary blocked until the primary also receives an end-of-interrupt.
- R12: A command-port write with bit 7 clear and a value other than 20h has no effect on the in-service set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request inputs, latched on rising edge |
| casc_en | input | 1 | Treat line 2 as the input from a secondary controller |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = command port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| inta | input | 1 | Interrupt acknowledge from the CPU |
| int_out | output | 1 | Interrupt request to the CPU |
| vec_valid | output | 1 | One-cycle strobe: `vec_out` holds a vector |
| vec_out | output | 8 | Base plus granted line number |
| casc_ack | output | 1 | Acknowledge forwarded to the secondary controller |

## Verification
The controller is exercised with the following request patterns:
- **Single request:** shows the basic edge-to-vector path.
- **Two simultaneous requests:** separates the fixed priority order from first-come ordering.
- **A higher request arriving during service:** shows that preemption works and that end-of-interrupt clears only the innermost line.
- **A repeat edge on a line already in service:** shows that the line is held off until its own end-of-interrupt.

Masked requests and base reprogramming check that the mask and the base stay independent. A two-controller chain, completed with an end-of-interrupt to the secondary only, shows that the primary still blocks line 2 until it gets its own end-of-interrupt.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [0:0] {
        ST_RUN        = 1'b0,
        ST_BASE_ARMED = 1'b1
    } cmd_state_e;

    localparam logic [7:0] CMD_EOI     = 8'h20;
    localparam int         CMD_ARM_BIT = 7;
endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
    parameter int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] bits,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = |bits;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/pic_line_slice.sv
module pic_line_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    input  logic take,
    input  logic retire,
    output logic pend_q,
    output logic serv_q
);
    logic req_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d  <= 1'b0;
            pend_q <= 1'b0;
            serv_q <= 1'b0;
        end else begin
            req_d  <= req_in;
            pend_q <= (pend_q & ~take) | (req_in & ~req_d);
            if (take)        serv_q <= 1'b1;
            else if (retire) serv_q <= 1'b0;
        end
    end
endmodule

// File: rtl/pic_cmd_fsm.sv
module pic_cmd_fsm
    import pic_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              eoi_pulse,
    output logic              mask_load,
    output logic              base_load
);
    cmd_state_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        eoi_pulse = 1'b0;
        mask_load = 1'b0;
        base_load = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (wr && addr) begin
                    mask_load = 1'b1;
                end else if (wr && wdata[CMD_ARM_BIT]) begin
                    state_nxt = ST_BASE_ARMED;             // arm
                end else if (wr && wdata == DATA_W'(CMD_EOI)) begin
                    eoi_pulse = 1'b1;
                end
            end
            ST_BASE_ARMED: begin
                if (wr && addr) begin
                    base_load = 1'b1;
                    state_nxt = ST_RUN;                    // load
                end else if (wr && !wdata[CMD_ARM_BIT]) begin
                    state_nxt = ST_RUN;                    // cancel
                    eoi_pulse = (wdata == DATA_W'(CMD_EOI));
                end
            end
            default: state_nxt = ST_RUN;
        endcase
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int              NUM_LINES  = 8,
    parameter int              DATA_W     = 8,
    parameter logic [DATA_W-1:0] RESET_BASE = 8'h08,
    parameter int              CASC_LINE  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 casc_en,
    input  logic                 bus_wr,
    input  logic                 bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 inta,
    output logic                 int_out,
    output logic                 vec_valid,
    output logic [DATA_W-1:0]    vec_out,
    output logic                 casc_ack
);
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [NUM_LINES-1:0] irr_vec, isr_vec, mask_q, take_vec, retire_vec;
    logic [DATA_W-1:0]    base_q;
    logic                 p_any, s_any, grant_ok, eoi_pulse, mask_load, base_load;
    logic [IDX_W-1:0]     p_idx, s_idx;

    pic_cmd_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .eoi_pulse(eoi_pulse),
        .mask_load(mask_load), .base_load(base_load)
    );

    pic_prio_enc #(.N(NUM_LINES)) u_pend_enc (
        .bits(irr_vec & ~mask_q), .any(p_any), .idx(p_idx)
    );

    pic_prio_enc #(.N(NUM_LINES)) u_serv_enc (
        .bits(isr_vec), .any(s_any), .idx(s_idx)
    );

    assign grant_ok = p_any && (!s_any || (p_idx < s_idx));
    assign int_out  = grant_ok;

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        assign take_vec[n]   = inta && grant_ok && (p_idx == IDX_W'(n));
        assign retire_vec[n] = eoi_pulse && s_any && (s_idx == IDX_W'(n));
        pic_line_slice u_slice (
            .clk(clk), .rst_n(rst_n), .req_in(irq_in[n]),
            .take(take_vec[n]), .retire(retire_vec[n]),
            .pend_q(irr_vec[n]), .serv_q(isr_vec[n])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            base_q <= RESET_BASE;
        end else begin
            if (mask_load) mask_q <= bus_wdata[NUM_LINES-1:0];
            if (base_load) base_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            casc_ack  <= 1'b0;
            vec_out   <= '0;
        end else begin
            vec_valid <= 1'b0;
            casc_ack  <= 1'b0;
            if (inta) begin
                if (grant_ok && casc_en && p_idx == IDX_W'(CASC_LINE)) begin
                    casc_ack <= 1'b1;
                end else begin
                    vec_valid <= 1'b1;
                    vec_out   <= base_q + (grant_ok ? DATA_W'(p_idx)
                                                    : DATA_W'(NUM_LINES - 1));
                end
            end
        end
    end
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         inta,
    input logic         int_out,
    input logic         vec_valid,
    input logic         casc_ack,
    input logic         eoi_pulse,
    input logic [N-1:0] irr,
    input logic [N-1:0] isr,
    input logic [N-1:0] mask
);
    a_r3_int_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~mask) != '0));

    a_r5_vector_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(inta));

    a_r5_ack_adds_one_service: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && int_out && !eoi_pulse) |=> ($countones(isr) == $countones($past(isr)) + 1));

    a_r8_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_pulse && isr != '0 && !inta) |=> ($countones(isr) + 1 == $countones($past(isr))));

    a_r10_cascade_no_vector: assert property (@(posedge clk) disable iff (!rst_n)
        casc_ack |-> !vec_valid);
endmodule

bind prio_irq_ctrl pic_ctrl_chk #(.N(NUM_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .inta(inta), .int_out(int_out),
    .vec_valid(vec_valid), .casc_ack(casc_ack), .eoi_pulse(eoi_pulse),
    .irr(irr_vec), .isr(isr_vec), .mask(mask_q)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] p_irq = '0, s_irq = '0;
    logic       casc_en = 1'b0;
    logic       p_wr = 1'b0, s_wr = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0;
    logic       inta = 1'b0;
    logic       int_out, vec_valid, casc_ack;
    logic [7:0] vec_out;
    logic       s_int, s_vv, s_ca;
    logic [7:0] s_vec;
    logic [7:0] p_lines;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    assign p_lines = {p_irq[7:3], casc_en ? s_int : p_irq[2], p_irq[1:0]};

    prio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(p_lines), .casc_en(casc_en),
        .bus_wr(p_wr), .bus_addr(addr), .bus_wdata(wdata), .inta(inta),
        .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out), .casc_ack(casc_ack)
    );

    prio_irq_ctrl #(.RESET_BASE(8'h70)) sec (
        .clk(clk), .rst_n(rst_n), .irq_in(s_irq), .casc_en(1'b0),
        .bus_wr(s_wr), .bus_addr(addr), .bus_wdata(wdata), .inta(casc_ack),
        .int_out(s_int), .vec_valid(s_vv), .vec_out(s_vec), .casc_ack(s_ca)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_p(input logic a, input logic [7:0] d);
        @(negedge clk); p_wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); p_wr = 1'b0;
    endtask

    task automatic wr_s(input logic a, input logic [7:0] d);
        @(negedge clk); s_wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); s_wr = 1'b0;
    endtask

    task automatic pulse_p(input logic [7:0] lines);
        @(negedge clk); p_irq = lines;
        @(negedge clk); p_irq = '0;
    endtask

    task automatic ack_expect(input string req, input logic [7:0] exp_vec);
        @(negedge clk); inta = 1'b1;
        @(negedge clk); inta = 1'b0;
        chk(req, {7'd0, vec_valid}, 8'd1);
        chk(req, vec_out, exp_vec);
    endtask

    task automatic t_reset;
        chk("R1 int_out", {7'd0, int_out}, 8'd0);
        chk("R1 vec_valid", {7'd0, vec_valid}, 8'd0);
        chk("R1 casc_ack", {7'd0, casc_ack}, 8'd0);
    endtask

    task automatic t_single;
        pulse_p(8'h20);
        chk("R2 int after edge", {7'd0, int_out}, 8'd1);
        ack_expect("R5 R1 vector base 08h", 8'h0D);
        chk("R6 int dropped while in service", {7'd0, int_out}, 8'd0);
        @(negedge clk);
        chk("R5 vec_valid single pulse", {7'd0, vec_valid}, 8'd0);
        wr_p(1'b0, 8'h20);
    endtask

    task automatic t_priority;
        pulse_p(8'h48);
        ack_expect("R4 lowest line wins", 8'h0B);
        chk("R6 lower line blocked", {7'd0, int_out}, 8'd0);
        wr_p(1'b0, 8'h20);
        chk("R6 lower line after eoi", {7'd0, int_out}, 8'd1);
        ack_expect("R4 second grant", 8'h0E);
        wr_p(1'b0, 8'h20);
    endtask

    task automatic t_preempt;
        pulse_p(8'h10);
        ack_expect("R5 line 4", 8'h0C);
        pulse_p(8'h02);
        chk("R6 higher preempts", {7'd0, int_out}, 8'd1);
        ack_expect("R6 nested vector", 8'h09);
        wr_p(1'b0, 8'h20);
        pulse_p(8'h40);
        chk("R8 eoi kept line 4 in service", {7'd0, int_out}, 8'd0);
        wr_p(1'b0, 8'h20);
        chk("R8 second eoi frees line 4", {7'd0, int_out}, 8'd1);
        ack_expect("R8 line 6 after", 8'h0E);
        wr_p(1'b0, 8'h20);
    endtask

    task automatic t_same_source;
        pulse_p(8'h08);
        ack_expect("R7 first", 8'h0B);
        pulse_p(8'h08);
        chk("R7 repeat blocked", {7'd0, int_out}, 8'd0);
        wr_p(1'b0, 8'h20);
        chk("R7 repeat after eoi", {7'd0, int_out}, 8'd1);
        ack_expect("R7 second", 8'h0B);
        wr_p(1'b0, 8'h20);
    endtask

    task automatic t_mask;
        wr_p(1'b1, 8'h20);
        pulse_p(8'h20);
        chk("R3 masked no int", {7'd0, int_out}, 8'd0);
        wr_p(1'b1, 8'h00);
        chk("R3 unmask raises int", {7'd0, int_out}, 8'd1);
        ack_expect("R3 latched vector", 8'h0D);
        wr_p(1'b0, 8'h20);
    endtask

    task automatic t_bad_cmd;
        pulse_p(8'h04);
        ack_expect("R12 line 2", 8'h0A);
        wr_p(1'b0, 8'h13);
        pulse_p(8'h20);
        chk("R12 unknown cmd kept service", {7'd0, int_out}, 8'd0);
        wr_p(1'b0, 8'h20);
        chk("R12 eoi then int", {7'd0, int_out}, 8'd1);
        ack_expect("R12 line 5", 8'h0D);
        wr_p(1'b0, 8'h20);
    endtask

    task automatic t_base;
        wr_p(1'b1, 8'h01);
        wr_p(1'b0, 8'h80);
        wr_p(1'b1, 8'h40);
        pulse_p(8'h01);
        chk("R9 mask kept after base load", {7'd0, int_out}, 8'd0);
        pulse_p(8'h80);
        chk("R9 int line 7", {7'd0, int_out}, 8'd1);
        ack_expect("R9 new base", 8'h47);
        wr_p(1'b0, 8'h20);
        wr_p(1'b1, 8'h00);
        ack_expect("R9 line 0 new base", 8'h40);
        wr_p(1'b0, 8'h20);
        wr_p(1'b0, 8'h80);
        wr_p(1'b1, 8'h08);
    endtask

    task automatic t_cascade;
        casc_en = 1'b1;
        @(negedge clk); s_irq = 8'h08;
        @(negedge clk); s_irq = 8'h00;
        @(negedge clk);
        chk("R10 primary int via cascade", {7'd0, int_out}, 8'd1);
        @(negedge clk); inta = 1'b1;
        @(negedge clk); inta = 1'b0;
        chk("R10 casc_ack", {7'd0, casc_ack}, 8'd1);
        chk("R10 no primary vector", {7'd0, vec_valid}, 8'd0);
        @(negedge clk);
        chk("R11 secondary vec_valid", {7'd0, s_vv}, 8'd1);
        chk("R11 secondary vector", s_vec, 8'h73);
        pulse_p(8'h20);
        wr_s(1'b0, 8'h20);
        chk("R11 primary still blocked", {7'd0, int_out}, 8'd0);
        wr_p(1'b0, 8'h20);
        chk("R11 primary eoi releases", {7'd0, int_out}, 8'd1);
        ack_expect("R11 primary line 5", 8'h0D);
        wr_p(1'b0, 8'h20);
        casc_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_priority();
        t_preempt();
        t_same_source();
        t_mask();
        t_bad_cmd();
        t_base();
        t_cascade();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule